// File: doc/BRIEF.md
# Change-Detection Interrupt Controller

This block watches a bank of synchronized digital inputs and raises a level interrupt when one of them makes a transition that software has asked to see. Each channel has its own rising-sensitivity bit and its own falling-sensitivity bit. Two global direction switches in the control register gate all rising or all falling detection at once.

A qualifying transition latches an event flag. A further qualifying transition that arrives while the event flag is still set latches an overflow flag. Each flag has its own interrupt enable. A master enable gates the interrupt line, and a status bit mirrors that line so a handler on a shared line can tell whether this device is the one interrupting. Software reads and writes the masks, control and status through a byte-wide register port. It acknowledges flags by writing ones to a clear register, and it can read a fixed identification byte.

Top module: `edge_irq_unit`

## Requirements
- R1: After reset every mask byte, the control register (0x15) and the status register (0x14) read 0x00, and irq_o is low.
- R2: Address 0x06 always reads 0x27, and writing it has no effect.
- R3: Rising-sensitivity bytes sit at 0x18..0x1A and falling-sensitivity bytes at 0x20..0x22. Channel n is bit n%8 of byte n/8. Each byte is written alone and reads back what was written.
- R4: When a channel with its rising bit set goes 0 to 1 while control bit 3 is 1, status bit 0 reads 1 from the clock edge that samples the new level. A rise on an unmasked channel, or a rise while control bit 3 is 0, latches nothing.
- R5: When a channel with its falling bit set goes 1 to 0 while control bit 4 is 1, status bit 0 is set in the same way. A fall on an unmasked channel, or a fall while control bit 4 is 0, latches nothing.
- R6: A qualifying transition seen while status bit 0 is already set, and not being cleared in that cycle, sets status bit 1 (overflow). Overflow then holds until it is cleared.
- R7: Writing 0x07 with bit 3 set clears status bit 0, and with bit 2 set clears status bit 1. Both may be cleared in one write. The other bits of that write have no effect.
- R8: irq_o is high exactly when control bit 2 (master) is 1 and either status bit 0 with control bit 0, or status bit 1 with control bit 1, is set. Status bit 2 reads the same value as irq_o. Writing 0 to control drops irq_o.
- R9: When a qualifying transition and a write clearing the event fall in the same cycle, the event stays set and no overflow is recorded.
- R10: Control at 0x15 holds bits 4..0 and reads them back, with bits 7..5 reading 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| din_i | input | 24 | Synchronized input channels |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 6 | Register byte address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i (combinational) |
| irq_o | output | 1 | Level interrupt request |

## Verification
A new qualifying transition and a software write to the clear register can land on the same clock edge. The bench provokes this by changing an input and issuing the event-clear write at the same falling clock edge, so that both reach the next rising edge together. It then reads the status register and expects the event still set with no overflow, because setting has priority over clearing and a transition that coincides with its own acknowledge is not counted as lost. The reverse case, where a transition hits a still-pending event, is checked separately and must raise overflow.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;
  localparam int unsigned AW = 6;
  localparam logic [AW-1:0] ADDR_ID   = 6'h06;
  localparam logic [AW-1:0] ADDR_CLR  = 6'h07;
  localparam logic [AW-1:0] ADDR_STAT = 6'h14;
  localparam logic [AW-1:0] ADDR_CTRL = 6'h15;
  localparam logic [AW-1:0] ADDR_RISE = 6'h18;
  localparam logic [AW-1:0] ADDR_FALL = 6'h20;
  localparam logic [7:0]    ID_VALUE  = 8'h27;
  localparam int unsigned   CLR_EVT_BIT = 3;
  localparam int unsigned   CLR_OVF_BIT = 2;

  // packed order gives fall_en = bit 4 ... evt_en = bit 0
  typedef struct packed {
    logic fall_en;
    logic rise_en;
    logic master_en;
    logic ovf_en;
    logic evt_en;
  } ctrl_t;
endpackage

// File: rtl/edge_irq_regs.sv
module edge_irq_regs
  import edge_irq_pkg::*;
#(
  parameter int unsigned N_CH = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      wdata_i,
  output logic [N_CH-1:0] rise_mask_o,
  output logic [N_CH-1:0] fall_mask_o,
  output ctrl_t           ctrl_o,
  output logic            clr_evt_o,
  output logic            clr_ovf_o
);
  localparam int unsigned NB = N_CH / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    localparam logic [AW-1:0] RA = ADDR_RISE + AW'(b);
    localparam logic [AW-1:0] FA = ADDR_FALL + AW'(b);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rise_mask_o[b*8 +: 8] <= '0;
        fall_mask_o[b*8 +: 8] <= '0;
      end else if (we_i) begin
        if (addr_i == RA) rise_mask_o[b*8 +: 8] <= wdata_i;
        if (addr_i == FA) fall_mask_o[b*8 +: 8] <= wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ctrl_o <= '0;
    else if (we_i && addr_i == ADDR_CTRL) ctrl_o <= ctrl_t'(wdata_i[4:0]);
  end

  logic clr_wr;
  assign clr_wr    = we_i && (addr_i == ADDR_CLR);
  assign clr_evt_o = clr_wr && wdata_i[CLR_EVT_BIT];
  assign clr_ovf_o = clr_wr && wdata_i[CLR_OVF_BIT];
endmodule

// File: rtl/edge_irq_detect.sv
module edge_irq_detect #(
  parameter int unsigned N_CH = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] din_i,
  input  logic [N_CH-1:0] rise_mask_i,
  input  logic [N_CH-1:0] fall_mask_i,
  input  logic            rise_en_i,
  input  logic            fall_en_i,
  output logic            hit_o
);
  logic [N_CH-1:0] prev_q;
  logic [N_CH-1:0] rise_vec, fall_vec;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= din_i;
  end

  assign rise_vec = din_i & ~prev_q & rise_mask_i;
  assign fall_vec = ~din_i & prev_q & fall_mask_i;
  assign hit_o    = (rise_en_i && (|rise_vec)) || (fall_en_i && (|fall_vec));

  // R4/R5: a hit needs an input that actually moved since the last cycle
  assert_hit_needs_change_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (din_i != prev_q));
endmodule

// File: rtl/edge_irq_flags.sv
module edge_irq_flags
  import edge_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  hit_i,
  input  logic  clr_evt_i,
  input  logic  clr_ovf_i,
  input  ctrl_t ctrl_i,
  output logic  evt_o,
  output logic  ovf_o,
  output logic  irq_o
);
  logic lost;
  // a hit coinciding with its own acknowledge is not lost
  assign lost = hit_i && evt_o && !clr_evt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o <= 1'b0;
      ovf_o <= 1'b0;
    end else begin
      if (hit_i)          evt_o <= 1'b1;
      else if (clr_evt_i) evt_o <= 1'b0;
      if (lost)           ovf_o <= 1'b1;
      else if (clr_ovf_i) ovf_o <= 1'b0;
    end
  end

  assign irq_o = ctrl_i.master_en &&
                 ((evt_o && ctrl_i.evt_en) || (ovf_o && ctrl_i.ovf_en));

  assert_evt_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i |=> evt_o);
  assert_evt_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(evt_o) |-> $past(hit_i));
  assert_ovf_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && evt_o && !clr_evt_i) |=> ovf_o);
  assert_ovf_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !clr_ovf_i) |=> ovf_o);
  assert_evt_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_evt_i && !hit_i) |=> !evt_o);
  assert_no_ovf_on_ack_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_evt_i && !ovf_o && !clr_ovf_i) |=> !ovf_o);
  assert_irq_master_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl_i.master_en);
endmodule

// File: rtl/edge_irq_unit.sv
module edge_irq_unit
  import edge_irq_pkg::*;
#(
  parameter int unsigned N_CH = 24
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] din_i,
  input  logic            we_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [7:0]      wdata_i,
  output logic [7:0]      rdata_o,
  output logic            irq_o
);
  localparam int unsigned NB = N_CH / 8;

  logic [N_CH-1:0] rise_mask, fall_mask;
  ctrl_t           ctrl;
  logic            clr_evt, clr_ovf, hit, evt, ovf;

  edge_irq_regs #(.N_CH(N_CH)) i_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .rise_mask_o(rise_mask), .fall_mask_o(fall_mask), .ctrl_o(ctrl),
    .clr_evt_o(clr_evt), .clr_ovf_o(clr_ovf)
  );

  edge_irq_detect #(.N_CH(N_CH)) i_detect (
    .clk_i, .rst_ni, .din_i,
    .rise_mask_i(rise_mask), .fall_mask_i(fall_mask),
    .rise_en_i(ctrl.rise_en), .fall_en_i(ctrl.fall_en), .hit_o(hit)
  );

  edge_irq_flags i_flags (
    .clk_i, .rst_ni, .hit_i(hit), .clr_evt_i(clr_evt), .clr_ovf_i(clr_ovf),
    .ctrl_i(ctrl), .evt_o(evt), .ovf_o(ovf), .irq_o
  );

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_ID:   rdata_o = ID_VALUE;
      ADDR_STAT: rdata_o = {5'b0, irq_o, ovf, evt};
      ADDR_CTRL: rdata_o = {3'b0, ctrl};
      default:   rdata_o = '0;
    endcase
    for (int b = 0; b < NB; b++) begin
      if (addr_i == ADDR_RISE + AW'(b)) rdata_o = rise_mask[b*8 +: 8];
      if (addr_i == ADDR_FALL + AW'(b)) rdata_o = fall_mask[b*8 +: 8];
    end
  end

  // R8: the status summary bit and the interrupt line never disagree
  assert_stat_mirrors_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == ADDR_STAT) |-> (rdata_o[2] == irq_o));
endmodule

// File: tb/test_edge_irq_unit.sv
module test_edge_irq_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] din = '0;
  logic        we = 1'b0;
  logic [5:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        irq;

  typedef struct {
    logic [5:0] a;
    logic       is_irq;
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  edge_irq_unit i_edge_irq_unit (
    .clk_i(clk), .rst_ni(rst_n), .din_i(din), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compares the design against each queued expectation
  initial begin
    forever begin
      wait (q.size() > 0);
      begin
        item_t it;
        logic [7:0] got;
        it = q.pop_front();
        got = it.is_irq ? {7'b0, irq} : rdata;
        n_chk++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: %s addr %h got %h expected %h", it.tag,
                   it.is_irq ? "irq" : "rd", it.a, got, it.exp);
        end
      end
    end
  end

  task automatic push(input logic [5:0] a, input logic is_irq,
                      input logic [7:0] e, input string tag);
    item_t it;
    addr = a;
    #2;
    it.a = a; it.is_irq = is_irq; it.exp = e; it.tag = tag;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic chk_rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    push(a, 1'b0, e, tag);
  endtask

  task automatic chk_irq(input logic e, input string tag);
    push(addr, 1'b1, {7'b0, e}, tag);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic set_din(input int ch, input logic v);
    @(negedge clk);
    din[ch] = v;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_rd(6'h14, 8'h00, "R1");
    chk_rd(6'h15, 8'h00, "R1");
    chk_rd(6'h18, 8'h00, "R1");
    chk_rd(6'h22, 8'h00, "R1");
    chk_irq(1'b0, "R1");

    // R2 identification
    chk_rd(6'h06, 8'h27, "R2");
    wr(6'h06, 8'h00);
    chk_rd(6'h06, 8'h27, "R2");

    // R3 mask bytes: rising ch0, ch15; falling ch22
    wr(6'h18, 8'h01);
    wr(6'h19, 8'h80);
    wr(6'h22, 8'h40);
    chk_rd(6'h18, 8'h01, "R3");
    chk_rd(6'h19, 8'h80, "R3");
    chk_rd(6'h1A, 8'h00, "R3");
    chk_rd(6'h20, 8'h00, "R3");
    chk_rd(6'h22, 8'h40, "R3");

    // R10 control width
    wr(6'h15, 8'hFF);
    chk_rd(6'h15, 8'h1F, "R10");

    // R4 global rising disabled: no event
    wr(6'h15, 8'h07);
    set_din(0, 1'b1);
    chk_rd(6'h14, 8'h00, "R4");
    set_din(0, 1'b0);
    chk_rd(6'h14, 8'h00, "R5");

    // R4 rising enabled, unmasked channel ignored
    wr(6'h15, 8'h0F);
    set_din(1, 1'b1);
    chk_rd(6'h14, 8'h00, "R4");
    set_din(15, 1'b1);
    chk_rd(6'h14, 8'h05, "R4");
    chk_irq(1'b1, "R8");

    // R7 clear bits other than 3 and 2 ignored
    wr(6'h07, 8'h03);
    chk_rd(6'h14, 8'h05, "R7");

    // R6 overflow
    set_din(0, 1'b1);
    chk_rd(6'h14, 8'h07, "R6");

    // R7 separate clears, R8 overflow keeps irq
    wr(6'h07, 8'h08);
    chk_rd(6'h14, 8'h06, "R7");
    chk_irq(1'b1, "R8");
    wr(6'h07, 8'h04);
    chk_rd(6'h14, 8'h00, "R7");
    chk_irq(1'b0, "R8");

    // R5 falling
    wr(6'h15, 8'h17);
    set_din(22, 1'b1);
    chk_rd(6'h14, 8'h00, "R5");
    set_din(15, 1'b0);
    chk_rd(6'h14, 8'h00, "R5");
    set_din(22, 1'b0);
    chk_rd(6'h14, 8'h05, "R5");

    // R8 gating by enables
    wr(6'h15, 8'h16);
    chk_rd(6'h14, 8'h01, "R8");
    chk_irq(1'b0, "R8");
    wr(6'h15, 8'h13);
    chk_irq(1'b0, "R8");
    wr(6'h15, 8'h17);
    chk_rd(6'h14, 8'h05, "R8");
    wr(6'h15, 8'h00);
    chk_irq(1'b0, "R8");
    chk_rd(6'h14, 8'h01, "R8");

    // R7 clear both in one write
    wr(6'h15, 8'h17);
    set_din(22, 1'b1);
    set_din(22, 1'b0);
    chk_rd(6'h14, 8'h07, "R6");
    wr(6'h07, 8'h0C);
    chk_rd(6'h14, 8'h00, "R7");
    chk_irq(1'b0, "R7");

    // R9 transition and event clear in the same cycle
    set_din(22, 1'b1);
    set_din(22, 1'b0);
    chk_rd(6'h14, 8'h05, "R9");
    set_din(22, 1'b1);
    @(negedge clk);
    din[22] = 1'b0;
    we = 1'b1; addr = 6'h07; wdata = 8'h08;
    @(negedge clk);
    we = 1'b0;
    chk_rd(6'h14, 8'h05, "R9");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule